// File: doc/BRIEF.md
# Power unit control and status registers

This block holds the configuration and status state of a microcontroller power unit behind a small register bus. A control word selects the deep-sleep behaviour, the supply-voltage detector (enable and 3-bit threshold), write access to the backup domain, flash power-down in stop mode and the performance mode. A status word carries the wakeup-pin enable and the backup regulator enable, together with five read-only flags: wakeup, standby, detector output, backup regulator ready and main regulator ready.

The analog parts are outside the block. The comparator result, the regulator ready levels, the standby-exit indication and the RTC event lines all arrive as inputs. The control fields leave as plain level outputs. The wakeup pin goes through a synchronizer, and an edge detector runs behind it. The wakeup and standby flags are cleared through command bits in the control word. These command bits never hold a value.

The block uses three reset domains. The power-on reset clears everything except the backup domain. The system reset clears everything except the standby flag and the backup domain. The backup-domain reset clears only the backup regulator enable and ready flag. The register bus always accepts an access and needs no handshake: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` shows the addressed word in the same cycle. There is no streamed data, so no port carries a valid/ready pair.

Top module: `pwr_ctl_regs`

## Requirements
- R1: The control word is at address 0x0. Its fields are deep-sleep low-power regulator select at bit 0, power-down deep-sleep select at bit 1, detector enable at bit 4, detector threshold at bits 7:5 (code 0 lowest to 7 highest level, driven on `det_lvl`), backup-domain write access at bit 8, flash power-down at bit 9 and performance mode at bit 14. All other bits, and any address other than 0x0 and 0x4, read 0 and ignore writes.
- R2: The status word is at address 0x4. Only wakeup-pin enable (bit 8) and backup regulator enable (bit 9) are writable. The flags sit at wakeup bit 0, standby bit 1, detector bit 2, backup ready bit 3 and main ready bit 14, and writes do not change them.
- R3: Writing a control word with bit 2 set clears the wakeup flag, and with bit 3 set clears the standby flag. Both command bits read back 0. A set condition in the same cycle wins over the clear.
- R4: While the wakeup pin is enabled, a rising edge on `wkup_pin` sets the wakeup flag at the third rising clock edge after the pin rises. While the pin is disabled, its edges have no effect.
- R5: A high on any bit of `rtc_evt` sets the wakeup flag at the next clock edge.
- R6: If the wakeup-pin enable is written from 0 to 1 while the synchronized pin is already high, the wakeup flag sets at the clock edge after the one that stores the enable.
- R7: A pulse on `stby_exit` sets the standby flag at the next edge. A system reset leaves the flag unchanged; a power-on reset clears it.
- R8: At each edge the detector flag takes the value detector-enable AND `det_below`, so it is 0 whenever the detector is disabled. A `stby_exit` pulse clears the detector enable, and this takes priority over a write in the same cycle.
- R9: `det_evt` is high for exactly the one cycle that follows each change of the detector flag.
- R10: At each edge the backup ready flag takes backup-regulator-enable AND `breg_ok`. The enable and the ready flag survive power-on and system resets and are cleared only by `bkp_rst_n`.
- R11: The main regulator ready flag follows `main_ok` one edge later.
- R12: A system or power-on reset clears the control word, the wakeup-pin enable, the wakeup flag, the detector flag and the main ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| bkp_rst_n | input | 1 | Backup-domain reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, same cycle |
| wkup_pin | input | 1 | Asynchronous wakeup pin |
| rtc_evt | input | NUM_RTC_EVT | RTC alarm, tamper, timestamp and wakeup event pulses |
| stby_exit | input | 1 | Pulse signalling a return from standby |
| det_below | input | 1 | Comparator result: supply below threshold |
| breg_ok | input | 1 | Backup regulator model output is in range |
| main_ok | input | 1 | Main regulator model output is in range |
| lpds_sel | output | 1 | Low-power regulator in deep sleep |
| pdds_sel | output | 1 | Power down in deep sleep |
| det_en | output | 1 | Detector enable |
| det_lvl | output | 3 | Detector threshold code |
| bkp_wr_en | output | 1 | Backup-domain write access |
| flash_pd | output | 1 | Flash power-down in stop mode |
| perf_mode | output | 1 | High-performance mode |
| wkup_pin_en | output | 1 | Wakeup pin enabled |
| breg_en | output | 1 | Backup regulator enable |
| det_evt | output | 1 | One-cycle pulse on detector flag change |

## Verification
The bench uses the default parameters: a 4-bit address, a 32-bit data word, a two-stage synchronizer and four RTC event lines. The 4-bit address leaves the unmapped words at 0x8 and 0xC within reach, so the bench can check that they ignore writes. The four event lines are pulsed one at a time to show that each of them sets the wakeup flag. The two synchronizer stages fix the pin-to-flag latency at three edges, and the bench reference model builds its pin history from the same depth.

// File: rtl/pwrc_pkg.sv
package pwrc_pkg;

  // control word field positions
  localparam int C_LPDS   = 0;
  localparam int C_PDDS   = 1;
  localparam int C_CLRWK  = 2;
  localparam int C_CLRSB  = 3;
  localparam int C_DETEN  = 4;
  localparam int C_LVL_LO = 5;
  localparam int C_LVL_W  = 3;
  localparam int C_BKACC  = 8;
  localparam int C_FPD    = 9;
  localparam int C_PERF   = 14;

  // status word field positions
  localparam int S_WUF    = 0;
  localparam int S_SBF    = 1;
  localparam int S_DET    = 2;
  localparam int S_BRR    = 3;
  localparam int S_WEN    = 8;
  localparam int S_BRE    = 9;
  localparam int S_MRDY   = 14;

  localparam int MIN_DATA_W = 15;

  typedef struct packed {
    logic               perf;
    logic               fpd;
    logic               bkacc;
    logic [C_LVL_W-1:0] lvl;
    logic               det_en;
    logic               pdds;
    logic               lpds;
  } ctrl_t;

  typedef struct packed {
    logic wuf;
    logic sbf;
    logic det;
    logic brr;
    logic mrdy;
  } flags_t;

endpackage

// File: rtl/pwrc_pin_sync.sv
module pwrc_pin_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_RTC_EVT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pin,
  input  logic                   pin_en,
  input  logic [NUM_RTC_EVT-1:0] rtc_evt,
  output logic                   wake_set
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   pin_s;
  logic                   pin_q;
  logic                   en_q;
  logic                   pin_rise;
  logic                   en_rise;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign pin_s = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      pin_q <= pin_s;
      en_q  <= pin_en;
    end
  end

  assign pin_rise = pin_s & ~pin_q;
  assign en_rise  = pin_en & ~en_q;
  assign wake_set = (pin_en & pin_rise) | (en_rise & pin_s) | (|rtc_evt);

  // R4: with the pin disabled and no RTC event nothing may request a wakeup
  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en && rtc_evt == '0) |-> !wake_set);

endmodule

// File: rtl/pwrc_flags.sv
module pwrc_flags (
  input  logic                  clk,
  input  logic                  core_rst_n,
  input  logic                  por_n,
  input  logic                  bkp_rst_n,
  input  logic                  wake_set,
  input  logic                  clr_wuf,
  input  logic                  stby_exit,
  input  logic                  clr_sbf,
  input  logic                  det_en,
  input  logic                  det_below,
  input  logic                  breg_en,
  input  logic                  breg_ok,
  input  logic                  main_ok,
  output pwrc_pkg::flags_t      flags,
  output logic                  det_evt
);

  logic wuf, sbf, det, det_q, brr, mrdy;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wuf   <= 1'b0;
      det   <= 1'b0;
      det_q <= 1'b0;
      mrdy  <= 1'b0;
    end else begin
      if (wake_set)     wuf <= 1'b1;
      else if (clr_wuf) wuf <= 1'b0;
      det   <= det_en & det_below;
      det_q <= det;
      mrdy  <= main_ok;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         sbf <= 1'b0;
    else if (stby_exit) sbf <= 1'b1;
    else if (clr_sbf)   sbf <= 1'b0;
  end

  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) brr <= 1'b0;
    else            brr <= breg_en & breg_ok;
  end

  assign det_evt    = det ^ det_q;
  assign flags.wuf  = wuf;
  assign flags.sbf  = sbf;
  assign flags.det  = det;
  assign flags.brr  = brr;
  assign flags.mrdy = mrdy;

  p_wake_sets_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    wake_set |=> wuf);

  p_clear_wins_alone_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clr_wuf && !wake_set) |=> !wuf);

  p_stby_sets_r7: assert property (@(posedge clk) disable iff (!por_n)
    stby_exit |=> sbf);

  p_det_off_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !det_en |=> !det);

  p_det_on_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (det_en && det_below) |=> det);

  p_brr_needs_en_r10: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    !breg_en |=> !brr);

endmodule

// File: rtl/pwrc_regs.sv
module pwrc_regs #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              bkp_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              stby_exit,
  input  pwrc_pkg::flags_t  flags,
  output pwrc_pkg::ctrl_t   ctrl,
  output logic              wkup_en,
  output logic              breg_en,
  output logic              clr_wuf,
  output logic              clr_sbf,
  output logic [DATA_W-1:0] bus_rdata
);
  import pwrc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic  sel_ctrl, sel_stat, wr_ctrl, wr_stat;
  ctrl_t ctrl_q, ctrl_wr;

  assign sel_ctrl = (bus_addr == A_CTRL);
  assign sel_stat = (bus_addr == A_STAT);
  assign wr_ctrl  = bus_wr & sel_ctrl;
  assign wr_stat  = bus_wr & sel_stat;

  always_comb begin
    ctrl_wr.lpds   = bus_wdata[C_LPDS];
    ctrl_wr.pdds   = bus_wdata[C_PDDS];
    ctrl_wr.det_en = bus_wdata[C_DETEN];
    ctrl_wr.lvl    = bus_wdata[C_LVL_LO +: C_LVL_W];
    ctrl_wr.bkacc  = bus_wdata[C_BKACC];
    ctrl_wr.fpd    = bus_wdata[C_FPD];
    ctrl_wr.perf   = bus_wdata[C_PERF];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ctrl_q  <= '0;
      wkup_en <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q <= ctrl_wr;
      if (stby_exit) ctrl_q.det_en <= 1'b0;
      if (wr_stat)   wkup_en <= bus_wdata[S_WEN];
    end
  end

  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n)   breg_en <= 1'b0;
    else if (wr_stat) breg_en <= bus_wdata[S_BRE];
  end

  assign clr_wuf = wr_ctrl & bus_wdata[C_CLRWK];
  assign clr_sbf = wr_ctrl & bus_wdata[C_CLRSB];
  assign ctrl    = ctrl_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[C_LPDS]                = ctrl_q.lpds;
      bus_rdata[C_PDDS]                = ctrl_q.pdds;
      bus_rdata[C_DETEN]               = ctrl_q.det_en;
      bus_rdata[C_LVL_LO +: C_LVL_W]   = ctrl_q.lvl;
      bus_rdata[C_BKACC]               = ctrl_q.bkacc;
      bus_rdata[C_FPD]                 = ctrl_q.fpd;
      bus_rdata[C_PERF]                = ctrl_q.perf;
    end else if (sel_stat) begin
      bus_rdata[S_WUF]  = flags.wuf;
      bus_rdata[S_SBF]  = flags.sbf;
      bus_rdata[S_DET]  = flags.det;
      bus_rdata[S_BRR]  = flags.brr;
      bus_rdata[S_WEN]  = wkup_en;
      bus_rdata[S_BRE]  = breg_en;
      bus_rdata[S_MRDY] = flags.mrdy;
    end
  end

  // R8: a standby exit always leaves the detector disabled
  p_stby_kills_det_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    stby_exit |=> !ctrl_q.det_en);

  // R1: a write aimed at neither word leaves the control word unchanged
  p_unmapped_write_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_wr && !sel_ctrl && !sel_stat && !stby_exit) |=> $stable(ctrl_q));

endmodule

// File: rtl/pwr_ctl_regs.sv
module pwr_ctl_regs #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CTRL_OFS    = 0,
  parameter int STAT_OFS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_RTC_EVT = 4
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   sys_rst_n,
  input  logic                   bkp_rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   wkup_pin,
  input  logic [NUM_RTC_EVT-1:0] rtc_evt,
  input  logic                   stby_exit,
  input  logic                   det_below,
  input  logic                   breg_ok,
  input  logic                   main_ok,
  output logic                   lpds_sel,
  output logic                   pdds_sel,
  output logic                   det_en,
  output logic [2:0]             det_lvl,
  output logic                   bkp_wr_en,
  output logic                   flash_pd,
  output logic                   perf_mode,
  output logic                   wkup_pin_en,
  output logic                   breg_en,
  output logic                   det_evt
);
  import pwrc_pkg::*;

  initial begin
    if (DATA_W < MIN_DATA_W) $error("DATA_W too small for the register layout");
    if (SYNC_STAGES < 1)     $error("SYNC_STAGES must be at least 1");
  end

  logic   core_rst_n;
  logic   wake_set;
  logic   clr_wuf, clr_sbf;
  ctrl_t  ctrl;
  flags_t flags;

  assign core_rst_n = por_n & sys_rst_n;

  pwrc_pin_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .NUM_RTC_EVT (NUM_RTC_EVT)
  ) u_pin (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .pin      (wkup_pin),
    .pin_en   (wkup_pin_en),
    .rtc_evt  (rtc_evt),
    .wake_set (wake_set)
  );

  pwrc_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS)
  ) u_regs (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .bkp_rst_n  (bkp_rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .stby_exit  (stby_exit),
    .flags      (flags),
    .ctrl       (ctrl),
    .wkup_en    (wkup_pin_en),
    .breg_en    (breg_en),
    .clr_wuf    (clr_wuf),
    .clr_sbf    (clr_sbf),
    .bus_rdata  (bus_rdata)
  );

  pwrc_flags u_flags (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .por_n      (por_n),
    .bkp_rst_n  (bkp_rst_n),
    .wake_set   (wake_set),
    .clr_wuf    (clr_wuf),
    .stby_exit  (stby_exit),
    .clr_sbf    (clr_sbf),
    .det_en     (ctrl.det_en),
    .det_below  (det_below),
    .breg_en    (breg_en),
    .breg_ok    (breg_ok),
    .main_ok    (main_ok),
    .flags      (flags),
    .det_evt    (det_evt)
  );

  assign lpds_sel  = ctrl.lpds;
  assign pdds_sel  = ctrl.pdds;
  assign det_en    = ctrl.det_en;
  assign det_lvl   = ctrl.lvl;
  assign bkp_wr_en = ctrl.bkacc;
  assign flash_pd  = ctrl.fpd;
  assign perf_mode = ctrl.perf;

endmodule

// File: tb/test_pwr_ctl_regs.sv
module test_pwr_ctl_regs;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int SY = 2;
  localparam int NE = 4;
  localparam logic [31:0] CMASK = 32'h0000_43F3;

  logic clk = 1'b0;
  logic por_n = 1'b0, sys_rst_n = 1'b0, bkp_rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wkup_pin = 1'b0;
  logic [NE-1:0] rtc_evt = '0;
  logic stby_exit = 1'b0, det_below = 1'b0, breg_ok = 1'b0, main_ok = 1'b0;
  logic lpds_sel, pdds_sel, det_en, bkp_wr_en, flash_pd, perf_mode;
  logic wkup_pin_en, breg_en, det_evt;
  logic [2:0] det_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SY), .NUM_RTC_EVT(NE)) i_pwr_ctl_regs (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wkup_pin(wkup_pin), .rtc_evt(rtc_evt), .stby_exit(stby_exit),
    .det_below(det_below), .breg_ok(breg_ok), .main_ok(main_ok),
    .lpds_sel(lpds_sel), .pdds_sel(pdds_sel), .det_en(det_en), .det_lvl(det_lvl),
    .bkp_wr_en(bkp_wr_en), .flash_pd(flash_pd), .perf_mode(perf_mode),
    .wkup_pin_en(wkup_pin_en), .breg_en(breg_en), .det_evt(det_evt)
  );

  // ---------------- behavioural reference model ----------------
  wire core_n = por_n & sys_rst_n;
  logic [31:0] m_ctrl = '0;
  logic m_wen = 0, m_wen_d = 0, m_wuf = 0, m_det = 0, m_det_d = 0, m_mrdy = 0;
  logic m_sbf = 0, m_bre = 0, m_brr = 0;
  bit   pin_hist[$];

  always @(posedge clk or negedge core_n) begin
    if (!core_n) begin
      m_ctrl <= '0; m_wen <= 0; m_wen_d <= 0; m_wuf <= 0;
      m_det <= 0; m_det_d <= 0; m_mrdy <= 0;
      pin_hist = {};
      for (int k = 0; k <= SY; k++) pin_hist.push_back(1'b0);
    end else begin
      bit seen, prev, wake;
      logic [31:0] nc;
      seen = pin_hist[SY-1];
      prev = pin_hist[SY];
      wake = (m_wen && seen && !prev) || (m_wen && !m_wen_d && seen) || (rtc_evt != 0);
      if (wake) m_wuf <= 1;
      else if (bus_wr && bus_addr == 0 && bus_wdata[2]) m_wuf <= 0;
      nc = m_ctrl;
      if (bus_wr && bus_addr == 0) nc = bus_wdata & CMASK;
      if (stby_exit) nc[4] = 1'b0;
      m_ctrl <= nc;
      if (bus_wr && bus_addr == 4) m_wen <= bus_wdata[8];
      m_wen_d <= m_wen;
      m_det   <= m_ctrl[4] & det_below;
      m_det_d <= m_det;
      m_mrdy  <= main_ok;
      pin_hist.push_front(wkup_pin);
      void'(pin_hist.pop_back());
    end
  end

  always @(posedge clk or negedge por_n) begin
    if (!por_n) m_sbf <= 0;
    else if (stby_exit) m_sbf <= 1;
    else if (bus_wr && bus_addr == 0 && bus_wdata[3]) m_sbf <= 0;
  end

  always @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n) begin
      m_bre <= 0; m_brr <= 0;
    end else begin
      if (bus_wr && bus_addr == 4) m_bre <= bus_wdata[9];
      m_brr <= m_bre & breg_ok;
    end
  end

  function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
    logic [31:0] s;
    s = '0;
    if (a == 0) return m_ctrl;
    if (a == 4) begin
      s[0] = m_wuf; s[1] = m_sbf; s[2] = m_det; s[3] = m_brr;
      s[8] = m_wen; s[9] = m_bre; s[14] = m_mrdy;
      return s;
    end
    return '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(bus_addr == 4 ? "R2 status read" : "R1 control read", bus_rdata, model_rd(bus_addr));
      chk("R1 control pins",
          {20'd0, lpds_sel, pdds_sel, det_en, det_lvl, bkp_wr_en, flash_pd, perf_mode},
          {20'd0, m_ctrl[0], m_ctrl[1], m_ctrl[4], m_ctrl[7:5], m_ctrl[8], m_ctrl[9], m_ctrl[14]});
      chk("R2 R10 enable pins", {30'd0, wkup_pin_en, breg_en}, {30'd0, m_wen, m_bre});
      chk("R9 detector event", {31'd0, det_evt}, {31'd0, m_det ^ m_det_d});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    step();
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 por_n = 1; sys_rst_n = 1; bkp_rst_n = 1;
    step();
    // R12 reset state
    rd(0, 32'h0, "R12 control after reset");
    rd(4, 32'h0, "R12 status after reset");

    // R1 field layout, reserved bits, R3 command bits read 0
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_43F3, "R1 R3 control readback");
    chk("R1 threshold pins", {29'd0, det_lvl}, 32'd7);

    // R2 writable status bits
    wr(4, 32'hFFFF_FFFF);
    step();
    rd(4, 32'h0000_0300, "R2 status readback");

    // R8 detector and R9 event
    det_below = 1;
    step();
    chk("R9 event pulse", {31'd0, det_evt}, 32'd1);
    step();
    chk("R9 event one cycle", {31'd0, det_evt}, 32'd0);
    rd(4, 32'h0000_0304, "R8 detector flag");

    // R4 pin edge with three-edge latency
    wkup_pin = 1;
    step(); rd(4, 32'h0000_0304, "R4 not yet edge 1");
    step(); rd(4, 32'h0000_0304, "R4 not yet edge 2");
    step(); rd(4, 32'h0000_0305, "R4 set at edge 3");

    // R3 clear
    wr(0, 32'h0000_43F7);
    rd(4, 32'h0000_0304, "R3 wakeup cleared");
    rd(0, 32'h0000_43F3, "R3 command reads 0");

    // R4 edges ignored while disabled
    wr(4, 32'h0000_0200);
    wkup_pin = 0; repeat (4) step();
    wkup_pin = 1; repeat (5) step();
    rd(4, 32'h0000_0204, "R4 disabled pin ignored");

    // R6 enable while high
    wr(4, 32'h0000_0300);
    step();
    rd(4, 32'h0000_0305, "R6 enable while high");

    // R5 each RTC line
    for (int i = 0; i < NE; i++) begin
      wr(0, 32'h0000_43F7);
      rd(4, 32'h0000_0304, "R5 cleared before event");
      rtc_evt = NE'(1) << i;
      step();
      rtc_evt = '0;
      rd(4, 32'h0000_0305, "R5 rtc event sets");
    end

    // R3 set wins over same-cycle clear
    step();
    bus_addr = 0; bus_wr = 1; bus_wdata = 32'h0000_43F7; rtc_evt = 1;
    step();
    bus_wr = 0; rtc_evt = '0;
    rd(4, 32'h0000_0305, "R3 set wins");

    // R7 standby flag, R8 detector disable on standby exit
    stby_exit = 1;
    step();
    stby_exit = 0;
    rd(0, 32'h0000_43E3, "R8 standby clears enable");
    step(); step();
    rd(4, 32'h0000_0303, "R7 R8 standby set, detector off");

    // R10 backup ready, R11 main ready
    breg_ok = 1; main_ok = 1;
    step(); step();
    rd(4, 32'h0000_430B, "R10 R11 ready flags");

    // R12 / R7 / R10 system reset
    sys_rst_n = 0; step(); sys_rst_n = 1;
    rd(0, 32'h0, "R12 control cleared by system reset");
    step(); step();
    rd(4, 32'h0000_420A, "R7 R10 survive system reset");

    // R7 power-on reset
    por_n = 0; step(); por_n = 1;
    step(); step();
    rd(4, 32'h0000_4208, "R7 R10 power-on reset");

    // R10 backup reset
    bkp_rst_n = 0; step(); bkp_rst_n = 1;
    step(); step();
    rd(4, 32'h0000_4000, "R10 backup reset");

    // R2 flags read-only, R1 unmapped address
    wr(4, 32'h0000_400F);
    step();
    rd(4, 32'h0000_4000, "R2 flags ignore writes");
    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h0, "R1 unmapped reads 0");
    rd(0, 32'h0, "R1 unmapped write ignored");

    // R1 threshold code, R8 flag tracks comparator
    wr(0, 32'h0000_00B0);
    chk("R1 threshold code 5", {29'd0, det_lvl}, 32'd5);
    step();
    rd(4, 32'h0000_4004, "R8 detector re-enabled");
    det_below = 0;
    step(); step();
    rd(4, 32'h0000_4000, "R8 supply above threshold");

    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule